// File: doc/BRIEF.md
# Load Multiple Word Sequencer

This block carries out a load-multiple-word operation over several cycles. The caller gives it a first destination register number and a first byte address. The sequencer then reads one 32-bit word from memory at a time and writes each word into the register file. The first word goes to the named register and each later word goes to the next register up. The run ends once register 31 has been written. Between words the read address moves forward by four bytes. Each word goes into the low half of a 64-bit register, and the upper half is cleared.

The memory side holds at most one read in flight. A one-cycle request carries the address, and the block waits for a valid strobe with the data before it issues the next request. Results leave through a registered write port that has an enable, a register number and 64-bit data. A `busy` flag covers the run and a one-cycle `done` pulse closes it. The caller forms the first address, including any base plus sign-extended displacement. Faults are handled outside this block, and the block changes no status state of its own.

Top module: `lmw_seq`

## Requirements
- R1: A `start` while idle is accepted. In the next cycle `busy` is 1, `mem_req` is 1 and `mem_addr` equals the captured `start_addr`.
- R2: The first register written is `start_reg`. Each later write targets the previous register plus one, and a run writes exactly 32 − `start_reg` registers, ending at register 31.
- R3: Each request after the first carries the previous request address plus 4, modulo 2^ADDR_W.
- R4: `wr_data` holds the word presented on `mem_data` in the cycle its `mem_valid` was accepted, in bits 31:0, with bits 63:32 zero, even when bit 31 of the word is set.
- R5: `mem_req` is a single-cycle pulse. No new request is issued until `mem_valid` has been accepted for the previous one, so at most one read is outstanding.
- R6: `wr_en` is high for exactly one cycle per accepted word, in the cycle after that word's `mem_valid`.
- R7: `done` is high for one cycle, in the cycle after the last register write. In that cycle `busy` is 0.
- R8: A `start` raised while `busy` is 1 has no effect: the run in progress keeps its registers and addresses and writes no extra words.
- R9: A `start_reg` of 31 produces exactly one memory read and one register write.
- R10: A `mem_valid` that arrives while no read is outstanding causes no register write.
- R11: During reset, `busy`, `mem_req`, `wr_en` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (accepted only when idle) |
| start_reg | input | 5 | First destination register number |
| start_addr | input | ADDR_W | First byte address to read |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | ADDR_W | Read address, valid while `mem_req` is 1 |
| mem_valid | input | 1 | Read data strobe for the outstanding request |
| mem_data | input | 32 | Read data word |
| wr_en | output | 1 | Register file write enable |
| wr_reg | output | 5 | Register number being written |
| wr_data | output | 64 | Zero-extended word being written |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
The bench builds the block with ADDR_W set to 16, with the word, register and data widths at their defaults. The narrow address lets a 32-register run that starts just below 0xFFFF carry across the top of the address space, which exercises the modulo behaviour of the address step. The registered last-register flag stays selected, so its early evaluation is compared against the reference model on every cycle. Memory latency rotates between zero and two idle cycles, so both back-to-back and stretched request/response spacing occur within a single run.

// File: rtl/lmw_pkg.sv
package lmw_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_FIN   = 2'd3
   } lmw_state_e;

endpackage

// File: rtl/lmw_ctrl.sv
module lmw_ctrl
   import lmw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic mem_valid,
   input  logic last,
   output logic load,
   output logic capture,
   output logic step,
   output logic issue,
   output logic busy,
   output logic done
);

   lmw_state_e st_q, st_d;
   logic       done_q;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:  if (start) st_d = ST_ISSUE;
         ST_ISSUE: st_d = ST_WAIT;
         ST_WAIT:  if (mem_valid) st_d = last ? ST_FIN : ST_ISSUE;
         ST_FIN:   st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= (st_q == ST_FIN);
      end
   end

   assign load    = (st_q == ST_IDLE) && start;
   assign capture = (st_q == ST_WAIT) && mem_valid;
   assign step    = capture && !last;
   assign issue   = (st_q == ST_ISSUE);
   assign busy    = (st_q != ST_IDLE);
   assign done    = done_q;

   // R5
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> !issue && busy);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(busy));

endmodule

// File: rtl/lmw_cursor.sv
module lmw_cursor #(
   parameter int ADDR_W          = 64,
   parameter int REG_IDX_W       = 5,
   parameter int LAST_REG        = 31,
   parameter int STRIDE          = 4,
   parameter bit LAST_REGISTERED = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic                 step,
   input  logic [REG_IDX_W-1:0] start_reg,
   input  logic [ADDR_W-1:0]    start_addr,
   output logic [REG_IDX_W-1:0] cur_reg,
   output logic [ADDR_W-1:0]    cur_addr,
   output logic                 last
);

   localparam logic [REG_IDX_W-1:0] LAST_IDX = REG_IDX_W'(LAST_REG);
   localparam logic [REG_IDX_W-1:0] PREV_IDX = REG_IDX_W'(LAST_REG - 1);
   localparam logic [ADDR_W-1:0]    STEP_AMT = ADDR_W'(STRIDE);

   logic [REG_IDX_W-1:0] reg_q;
   logic [ADDR_W-1:0]    addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q  <= '0;
         addr_q <= '0;
      end else if (load) begin
         reg_q  <= start_reg;
         addr_q <= start_addr;
      end else if (step) begin
         reg_q  <= reg_q + 1'b1;
         addr_q <= addr_q + STEP_AMT;
      end
   end

   assign cur_reg  = reg_q;
   assign cur_addr = addr_q;

   generate
      if (LAST_REGISTERED) begin : g_last_reg
         logic last_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    last_q <= (LAST_IDX == '0);
            else if (load) last_q <= (start_reg == LAST_IDX);
            else if (step) last_q <= (reg_q == PREV_IDX);
         end
         assign last = last_q;

         // R9
         last_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
            last == (reg_q == LAST_IDX));
      end else begin : g_last_cmp
         assign last = (reg_q == LAST_IDX);
      end
   endgenerate

   // R3
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> addr_q == $past(addr_q) + STEP_AMT);

   // R2
   reg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> reg_q == $past(reg_q) + 1'b1);

endmodule

// File: rtl/lmw_wb.sv
module lmw_wb #(
   parameter int XLEN      = 64,
   parameter int WORD_W    = 32,
   parameter int REG_IDX_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 capture,
   input  logic [REG_IDX_W-1:0] cur_reg,
   input  logic [WORD_W-1:0]    mem_data,
   output logic                 wr_en,
   output logic [REG_IDX_W-1:0] wr_reg,
   output logic [XLEN-1:0]      wr_data
);

   logic [XLEN-1:0] widened;

   generate
      if (XLEN == WORD_W) begin : g_same
         assign widened = mem_data;
      end else begin : g_pad
         localparam int PAD_W = XLEN - WORD_W;
         assign widened = {{PAD_W{1'b0}}, mem_data};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_reg  <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= capture;
         if (capture) begin
            wr_reg  <= cur_reg;
            wr_data <= widened;
         end
      end
   end

   // R6
   wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

endmodule

// File: rtl/lmw_seq.sv
module lmw_seq #(
   parameter int XLEN            = 64,
   parameter int WORD_W          = 32,
   parameter int ADDR_W          = 64,
   parameter int REG_CNT         = 32,
   parameter bit LAST_REGISTERED = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [$clog2(REG_CNT)-1:0] start_reg,
   input  logic [ADDR_W-1:0]          start_addr,
   output logic                       mem_req,
   output logic [ADDR_W-1:0]          mem_addr,
   input  logic                       mem_valid,
   input  logic [WORD_W-1:0]          mem_data,
   output logic                       wr_en,
   output logic [$clog2(REG_CNT)-1:0] wr_reg,
   output logic [XLEN-1:0]            wr_data,
   output logic                       busy,
   output logic                       done
);

   localparam int REG_IDX_W = $clog2(REG_CNT);
   localparam int LAST_REG  = REG_CNT - 1;
   localparam int STRIDE    = WORD_W / 8;

   generate
      if (WORD_W % 8 != 0) begin : g_bad_word
         $error("WORD_W must be a whole number of bytes");
      end
      if (XLEN < WORD_W) begin : g_bad_xlen
         $error("XLEN must be at least WORD_W");
      end
      if (REG_CNT < 2 || (1 << REG_IDX_W) != REG_CNT) begin : g_bad_regs
         $error("REG_CNT must be a power of two of at least 2");
      end
      if (ADDR_W <= $clog2(STRIDE)) begin : g_bad_addr
         $error("ADDR_W too narrow for the word stride");
      end
   endgenerate

   logic                 load, capture, step, issue, last;
   logic [REG_IDX_W-1:0] cur_reg;
   logic [ADDR_W-1:0]    cur_addr;

   lmw_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mem_valid (mem_valid),
      .last      (last),
      .load      (load),
      .capture   (capture),
      .step      (step),
      .issue     (issue),
      .busy      (busy),
      .done      (done)
   );

   lmw_cursor #(
      .ADDR_W          (ADDR_W),
      .REG_IDX_W       (REG_IDX_W),
      .LAST_REG        (LAST_REG),
      .STRIDE          (STRIDE),
      .LAST_REGISTERED (LAST_REGISTERED)
   ) u_cursor (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .step       (step),
      .start_reg  (start_reg),
      .start_addr (start_addr),
      .cur_reg    (cur_reg),
      .cur_addr   (cur_addr),
      .last       (last)
   );

   lmw_wb #(
      .XLEN      (XLEN),
      .WORD_W    (WORD_W),
      .REG_IDX_W (REG_IDX_W)
   ) u_wb (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (capture),
      .cur_reg  (cur_reg),
      .mem_data (mem_data),
      .wr_en    (wr_en),
      .wr_reg   (wr_reg),
      .wr_data  (wr_data)
   );

   assign mem_req  = issue;
   assign mem_addr = cur_addr;

   // R4
   zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wr_data == XLEN'($past(mem_data)));

   // R10
   stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && mem_valid) |=> !wr_en);

   // R1
   start_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> mem_req && mem_addr == $past(start_addr));

endmodule

// File: tb/tb_lmw_seq.sv
module tb_lmw_seq;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [4:0]    start_reg = '0;
   logic [AW-1:0] start_addr = '0;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic          mem_valid = 1'b0;
   logic [31:0]   mem_data = 32'hDEAD_BEEF;
   logic          wr_en;
   logic [4:0]    wr_reg;
   logic [63:0]   wr_data;
   logic          busy, done;

   lmw_seq #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_reg(start_reg),
      .start_addr(start_addr), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_valid(mem_valid), .mem_data(mem_data), .wr_en(wr_en),
      .wr_reg(wr_reg), .wr_data(wr_data), .busy(busy), .done(done)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int op_writes = 0;
   int op_done = 0;
   int op_reqs = 0;
   bit spur = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] mdata(input logic [AW-1:0] a);
      return {~a, a ^ 16'h3C5A};
   endfunction

   // memory responder
   bit            pend = 1'b0;
   int            wcnt = 0;
   int            lat_sel = 0;
   logic [AW-1:0] paddr = '0;
   always @(negedge clk) begin
      mem_valid = 1'b0;
      mem_data  = 32'hDEAD_BEEF;
      if (pend) begin
         if (wcnt == 0) begin
            mem_valid = 1'b1;
            mem_data  = mdata(paddr);
            pend      = 1'b0;
         end else begin
            wcnt--;
         end
      end
      if (spur) begin
         mem_valid = 1'b1;
         mem_data  = 32'h1234_5678;
      end
      if (rst_n && mem_req) begin
         pend    = 1'b1;
         paddr   = mem_addr;
         wcnt    = lat_sel;
         lat_sel = (lat_sel + 1) % 3;
      end
   end

   // behavioural reference model
   int            m_st = 0;
   int            m_reg = 0;
   logic [AW-1:0] m_addr = '0;
   bit            e_wr = 1'b0;
   int            e_wreg = 0;
   logic [63:0]   e_wdata = '0;
   bit            e_done = 1'b0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; e_wr = 1'b0; e_done = 1'b0; e_wdata = '0; e_wreg = 0;
      end else begin
         e_wr = 1'b0;
         e_done = 1'b0;
         if (m_st == 0) begin
            if (start) begin
               m_reg = start_reg; m_addr = start_addr; m_st = 1;
            end
         end else if (m_st == 1) begin
            m_st = 2;
         end else if (m_st == 2) begin
            if (mem_valid) begin
               e_wr = 1'b1; e_wreg = m_reg; e_wdata = {32'h0, mem_data};
               if (m_reg == 31) m_st = 3;
               else begin
                  m_reg = m_reg + 1; m_addr = m_addr + 16'd4; m_st = 1;
               end
            end
         end else begin
            e_done = 1'b1; m_st = 0;
         end
      end
   end

   // compare every cycle
   always begin
      @(posedge clk);
      #5;
      if (rst_n) begin
         chk(busy == (m_st != 0), "R1 busy", 64'(busy), 64'(m_st != 0));
         chk(mem_req == (m_st == 1), "R5 mem_req", 64'(mem_req), 64'(m_st == 1));
         if (m_st == 1)
            chk(mem_addr == m_addr, "R3 mem_addr", 64'(mem_addr), 64'(m_addr));
         chk(wr_en == e_wr, "R6 wr_en", 64'(wr_en), 64'(e_wr));
         if (e_wr) begin
            chk(wr_reg == 5'(e_wreg), "R2 wr_reg", 64'(wr_reg), 64'(e_wreg));
            chk(wr_data == e_wdata, "R4 wr_data", wr_data, e_wdata);
         end
         chk(done == e_done, "R7 done", 64'(done), 64'(e_done));
         if (wr_en) op_writes++;
         if (done) op_done++;
         if (mem_req) op_reqs++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000) begin
         failures++;
         $display("FAIL watchdog act=%0d exp<=60000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic run_op(input int sreg, input logic [AW-1:0] saddr,
                         input bit intrude);
      @(negedge clk);
      op_writes = 0; op_done = 0; op_reqs = 0;
      start = 1'b1; start_reg = 5'(sreg); start_addr = saddr;
      @(negedge clk);
      start = 1'b0; start_reg = 5'd7; start_addr = 16'hBEEF;
      if (intrude) begin
         repeat (3) @(negedge clk);
         start = 1'b1; start_reg = 5'd5; start_addr = 16'h4000;
         @(negedge clk);
         start = 1'b0;
      end
      for (int i = 0; i < 2000 && op_done == 0; i++) @(negedge clk);
      chk(op_writes == 32 - sreg, "R2 write count", 64'(op_writes), 64'(32 - sreg));
      chk(op_done == 1, "R7 done count", 64'(op_done), 64'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset values
      chk(!busy, "R11 busy", 64'(busy), 64'd0);
      chk(!mem_req, "R11 mem_req", 64'(mem_req), 64'd0);
      chk(!wr_en, "R11 wr_en", 64'(wr_en), 64'd0);
      chk(!done, "R11 done", 64'(done), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 start accepted, four registers, high data bit set for R4
      run_op(28, 16'h0100, 1'b0);

      // R9 single word
      run_op(31, 16'h0220, 1'b0);
      chk(op_reqs == 1, "R9 request count", 64'(op_reqs), 64'd1);

      // R3 full run crossing the top of the address space
      run_op(0, 16'hFFC0, 1'b0);
      chk(op_reqs == 32, "R5 request count", 64'(op_reqs), 64'd32);

      // R8 start while busy ignored
      run_op(26, 16'h0800, 1'b1);
      chk(op_reqs == 6, "R8 request count", 64'(op_reqs), 64'd6);

      // R10 stray valid while idle
      @(negedge clk);
      op_writes = 0;
      spur = 1'b1;
      repeat (3) @(negedge clk);
      spur = 1'b0;
      repeat (3) @(negedge clk);
      chk(op_writes == 0, "R10 stray writes", 64'(op_writes), 64'd0);
      chk(!busy, "R10 stays idle", 64'(busy), 64'd0);

      // back-to-back after done
      run_op(30, 16'h1000, 1'b0);

      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule